// File: doc/BRIEF.md
# DAC Serial Register Interface

This block is the digital front end of an 18-bit voltage-output DAC. A host sends 24-bit command frames over a three-wire link made of an active-low frame select, a serial clock and a data line. Each frame holds a read/write flag, a 3-bit register address and a 20-bit payload. The block decodes each frame and updates a small register file: the DAC code register, a control register, a clear-code register and a write-only software-control register whose bits act as one-cycle strobes.

The serial pins are brought into the system clock domain through synchronizers and oversampled. The data line is sampled on the falling serial-clock edge. A read frame arms a readback. The next frame then returns the addressed register's 24-bit image on a data-out pin, most significant bit first, while the new command shifts in. The converter code that drives the analog stage is held in a separate output register. That register only moves when a load strobe arrives, so writing the DAC code register does not by itself change the analog output. The control register is presented directly as parallel bits.

Top module: `dac_serial_regif`

## Requirements
- R1: During and after reset, `dac_code` equals RESET_CODE (default 0, the code for 0 V), `ctrl_bits` is 0 and `sdo` is 0.
- R2: A write frame (bit 23 = 0) with address 001 stores payload bits 19:2 in the DAC code register. Payload bits 1:0 are ignored. `dac_code` does not change as a result of this write.
- R3: A write frame with address 010 stores all 20 payload bits in the control register, which appears on `ctrl_bits` once the frame ends.
- R4: A write frame with address 000 is a no-operation and leaves every register and output unchanged, whatever its payload.
- R5: A frame in which frame select rises after fewer or more than 24 falling serial-clock edges is discarded, and no register changes.
- R6: After a read frame (bit 23 = 1) for address 001, 010 or 011, the next frame shifts out {1, address, register data} on `sdo`, MSB first. Each bit is valid before the falling edge that samples the matching input bit. The DAC and clear-code images carry the 18-bit value in bits 19:2 with bits 1:0 at zero.
- R7: A read of address 100 returns {1, 100, 20'h0}. A read frame changes no register, whatever its payload.
- R8: A write to address 100 with payload bit 0 set copies the DAC code register to `dac_code`.
- R9: A write to address 100 with payload bit 1 set loads the clear code (written at address 011, payload bits 19:2) into the DAC code register. When bits 0 and 1 are both set, `dac_code` receives the clear code.
- R10: A write to address 100 with payload bit 2 set returns all registers and `dac_code` to their reset values. This takes priority over bits 0 and 1.
- R11: A frame that does not follow a read frame shifts all zeros out on `sdo`.
- R12: Write frames to addresses 101, 110 and 111 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock; idles high, data sampled on its falling edge |
| sdi | input | 1 | Serial command data, MSB first |
| sdo | output | 1 | Serial readback data, changes after rising serial-clock edges |
| dac_code | output | CODE_W (18) | Code presented to the converter |
| ctrl_bits | output | DATA_W (20) | Contents of the control register |

## Verification
The bench builds the block with its defaults: an 18-bit code in a 20-bit payload and two synchronizer stages. The serial clock runs at one eighth of the system clock. With these values, the two ignored low payload bits, the full 24-bit readback image and the discard of 23-edge and 25-edge frames can all be checked against a reference model of the register file. The strobe combinations of the software-control register, including reset priority and simultaneous clear and load, are reached with directed frames.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_NOP  = 3'd0,
    RA_CODE = 3'd1,
    RA_CTRL = 3'd2,
    RA_CLR  = 3'd3,
    RA_SOFT = 3'd4
  } reg_addr_e;

  localparam int SOFT_LOAD  = 0;
  localparam int SOFT_CLEAR = 1;
  localparam int SOFT_RESET = 2;
endpackage

// File: rtl/dsr_sync.sv
module dsr_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{INIT[b]}};
      else     chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/dsr_frame.sv
module dsr_frame #(
  parameter int FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fn_s,
  input  logic               sck_s,
  input  logic               sd_s,
  input  logic [FRAME_W-1:0] tx_image,
  output logic               frm_start,
  output logic               sck_rise,
  output logic               frm_vld,
  output logic [FRAME_W-1:0] frm_word,
  output logic               sdo
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

  logic               fn_q, sck_q;
  logic               sck_fall, frm_end;
  logic [CNT_W-1:0]   cnt;
  logic               ovf;
  logic [FRAME_W-1:0] rx_sh, tx_sh;

  assign frm_start = fn_q & ~fn_s;
  assign frm_end   = ~fn_q & fn_s;
  assign sck_fall  = sck_q & ~sck_s & ~fn_s;
  assign sck_rise  = ~sck_q & sck_s & ~fn_s;
  assign sdo       = tx_sh[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      fn_q     <= 1'b1;
      sck_q    <= 1'b1;
      cnt      <= '0;
      ovf      <= 1'b0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      frm_vld  <= 1'b0;
      frm_word <= '0;
    end else begin
      fn_q    <= fn_s;
      sck_q   <= sck_s;
      frm_vld <= 1'b0;
      if (frm_start) begin
        cnt   <= '0;
        ovf   <= 1'b0;
        tx_sh <= tx_image;
      end else begin
        if (sck_fall) begin
          rx_sh <= {rx_sh[FRAME_W-2:0], sd_s};
          if (cnt == FULL) ovf <= 1'b1;
          else             cnt <= cnt + 1'b1;
        end
        if (sck_rise) tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
      end
      if (frm_end) begin
        frm_vld  <= (cnt == FULL) && !ovf;
        frm_word <= rx_sh;
      end
    end
  end
endmodule

// File: rtl/dsr_regfile.sv
module dsr_regfile
  import dsr_pkg::*;
#(
  parameter int CODE_W = 18,
  parameter int DATA_W = 20,
  parameter logic [CODE_W-1:0] RESET_CODE = '0,
  parameter logic [DATA_W-1:0] CTRL_RESET = '0,
  localparam int FRAME_W = 1 + ADDR_W + DATA_W,
  localparam int PAD_W = DATA_W - CODE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frm_start,
  input  logic               frm_vld,
  input  logic [FRAME_W-1:0] frm_word,
  output logic [FRAME_W-1:0] tx_image,
  output logic [CODE_W-1:0]  dac_code,
  output logic [DATA_W-1:0]  ctrl_bits
);
  logic               rd_flag;
  reg_addr_e          addr;
  logic [DATA_W-1:0]  payload;
  logic [CODE_W-1:0]  code_reg, clr_reg;
  logic [DATA_W-1:0]  ctrl_reg;
  logic               rd_pend;
  reg_addr_e          rd_addr;
  logic [DATA_W-1:0]  rd_data;
  logic               soft_rst;

  assign rd_flag  = frm_word[FRAME_W-1];
  assign addr     = reg_addr_e'(frm_word[DATA_W +: ADDR_W]);
  assign payload  = frm_word[DATA_W-1:0];
  assign soft_rst = frm_vld && !rd_flag && addr == RA_SOFT && payload[SOFT_RESET];

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      code_reg <= RESET_CODE;
      clr_reg  <= RESET_CODE;
      ctrl_reg <= CTRL_RESET;
      dac_code <= RESET_CODE;
      rd_pend  <= 1'b0;
      rd_addr  <= RA_NOP;
    end else begin
      if (frm_start) rd_pend <= 1'b0;
      if (frm_vld) begin
        if (rd_flag) begin
          rd_pend <= 1'b1;
          rd_addr <= addr;
        end else begin
          case (addr)
            RA_CODE: code_reg <= payload[DATA_W-1:PAD_W];
            RA_CTRL: ctrl_reg <= payload;
            RA_CLR:  clr_reg  <= payload[DATA_W-1:PAD_W];
            RA_SOFT: begin
              if (payload[SOFT_CLEAR]) code_reg <= clr_reg;
              if (payload[SOFT_LOAD])
                dac_code <= payload[SOFT_CLEAR] ? clr_reg : code_reg;
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    case (rd_addr)
      RA_CODE: rd_data = {code_reg, {PAD_W{1'b0}}};
      RA_CTRL: rd_data = ctrl_reg;
      RA_CLR:  rd_data = {clr_reg, {PAD_W{1'b0}}};
      default: rd_data = '0;
    endcase
  end

  assign tx_image  = rd_pend ? {1'b1, rd_addr, rd_data} : '0;
  assign ctrl_bits = ctrl_reg;
endmodule

// File: rtl/dac_serial_regif.sv
module dac_serial_regif
  import dsr_pkg::*;
#(
  parameter int CODE_W = 18,
  parameter int DATA_W = 20,
  parameter int SYNC_STAGES = 2,
  parameter logic [CODE_W-1:0] RESET_CODE = '0,
  parameter logic [DATA_W-1:0] CTRL_RESET = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic [CODE_W-1:0] dac_code,
  output logic [DATA_W-1:0] ctrl_bits
);
  localparam int FRAME_W = 1 + ADDR_W + DATA_W;

  logic [2:0]         pins_s;
  logic               frm_start, sck_rise, frm_vld;
  logic [FRAME_W-1:0] frm_word, tx_image;

  dsr_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b110)) u_sync (
    .clk(clk), .rst(rst), .d({frame_n, sclk, sdi}), .q(pins_s)
  );

  dsr_frame #(.FRAME_W(FRAME_W)) u_frame (
    .clk(clk), .rst(rst),
    .fn_s(pins_s[2]), .sck_s(pins_s[1]), .sd_s(pins_s[0]),
    .tx_image(tx_image), .frm_start(frm_start), .sck_rise(sck_rise),
    .frm_vld(frm_vld), .frm_word(frm_word), .sdo(sdo)
  );

  dsr_regfile #(
    .CODE_W(CODE_W), .DATA_W(DATA_W),
    .RESET_CODE(RESET_CODE), .CTRL_RESET(CTRL_RESET)
  ) u_regs (
    .clk(clk), .rst(rst), .frm_start(frm_start), .frm_vld(frm_vld),
    .frm_word(frm_word), .tx_image(tx_image),
    .dac_code(dac_code), .ctrl_bits(ctrl_bits)
  );
endmodule

// File: rtl/dsr_checker.sv
module dsr_checker #(
  parameter int CODE_W = 18,
  parameter int DATA_W = 20,
  parameter logic [CODE_W-1:0] RESET_CODE = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              frm_vld,
  input logic              frm_start,
  input logic              sck_rise,
  input logic              sdo,
  input logic [CODE_W-1:0] dac_code,
  input logic [DATA_W-1:0] ctrl_bits
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always @(posedge clk) begin
    if (rst_q === 1'b1) begin
      AST_RESET_STATE: assert (dac_code == RESET_CODE && ctrl_bits == '0 && sdo == 1'b0); // R1
    end
  end

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frm_vld |=> $stable(dac_code)); // R2

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frm_vld |=> $stable(ctrl_bits)); // R3

  AST_SDO_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(sck_rise || frm_start) |=> $stable(sdo)); // R6

  AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    frm_vld |=> !frm_vld); // R5
endmodule

bind dac_serial_regif dsr_checker #(
  .CODE_W(CODE_W), .DATA_W(DATA_W), .RESET_CODE(RESET_CODE)
) u_chk (
  .clk(clk), .rst(rst), .frm_vld(frm_vld), .frm_start(frm_start),
  .sck_rise(sck_rise), .sdo(sdo), .dac_code(dac_code), .ctrl_bits(ctrl_bits)
);

// File: tb/dac_serial_regif_test.sv
module dac_serial_regif_test;
  logic clk = 1'b0, rst = 1'b1, frame_n = 1'b1, sclk = 1'b1, sdi = 1'b0;
  logic        sdo;
  logic [17:0] dac_code;
  logic [19:0] ctrl_bits;

  int n_cmp = 0, n_bad = 0;
  bit ended = 1'b0;
  logic [17:0] m_code = '0, m_out = '0, m_clr = '0;
  logic [19:0] m_ctrl = '0;

  always #5 clk = ~clk;

  dac_serial_regif uut (
    .clk(clk), .rst(rst), .frame_n(frame_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .dac_code(dac_code), .ctrl_bits(ctrl_bits)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic frame(input logic [23:0] w, input int nbits, output logic [23:0] got);
    got = '0;
    frame_n = 1'b0;
    #40;
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 24) ? w[23-i] : 1'b0;
      #40;
      if (i < 24) got[23-i] = sdo;
      sclk = 1'b0;
      #40;
      sclk = 1'b1;
    end
    #40;
    frame_n = 1'b1;
    sdi = 1'b0;
    #200;
  endtask

  task automatic wr(input logic [2:0] a, input logic [19:0] d);
    logic [23:0] g;
    frame({1'b0, a, d}, 24, g);
  endtask

  task automatic rd(input logic [2:0] a, output logic [23:0] got);
    logic [23:0] g;
    frame({1'b1, a, 20'hABCDE}, 24, g);
    frame(24'h0, 24, got);
  endtask

  task automatic check_outputs(input string req);
    check(req, 32'(dac_code), 32'(m_out));
    check(req, 32'(ctrl_bits), 32'(m_ctrl));
  endtask

  task automatic t_reset();
    check("R1 dac_code", 32'(dac_code), 32'h0);
    check("R1 ctrl_bits", 32'(ctrl_bits), 32'h0);
    check("R1 sdo", 32'(sdo), 32'h0);
  endtask

  task automatic t_nop_and_idle();
    logic [23:0] g;
    frame({1'b0, 3'b000, 20'hFFFFF}, 24, g);
    check("R11 sdo zero without read", 32'(g), 32'h0);
    check_outputs("R4 nop");
  endtask

  task automatic t_code_write();
    logic [23:0] g;
    m_code = 18'h2A5C3;
    wr(3'b001, {m_code, 2'b11});
    check("R2 dac_code held", 32'(dac_code), 32'(m_out));
    wr(3'b000, 20'h12345);
    rd(3'b001, g);
    check("R6 R4 code readback", 32'(g), 32'({1'b1, 3'b001, m_code, 2'b00}));
  endtask

  task automatic t_load();
    wr(3'b100, 20'h00001);
    m_out = m_code;
    check("R8 load", 32'(dac_code), 32'(m_out));
  endtask

  task automatic t_ctrl();
    logic [23:0] g;
    m_ctrl = 20'h9C3A5;
    wr(3'b010, m_ctrl);
    check("R3 ctrl_bits", 32'(ctrl_bits), 32'(m_ctrl));
    rd(3'b010, g);
    check("R6 ctrl readback", 32'(g), 32'({1'b1, 3'b010, m_ctrl}));
  endtask

  task automatic t_clear();
    logic [23:0] g;
    m_clr = 18'h1F00F;
    wr(3'b011, {m_clr, 2'b10});
    rd(3'b011, g);
    check("R6 clear readback", 32'(g), 32'({1'b1, 3'b011, m_clr, 2'b00}));
    wr(3'b100, 20'h00002);
    m_code = m_clr;
    check("R9 clear keeps output", 32'(dac_code), 32'(m_out));
    rd(3'b001, g);
    check("R9 clear into code reg", 32'(g), 32'({1'b1, 3'b001, m_code, 2'b00}));
    m_code = 18'h00777;
    wr(3'b001, {m_code, 2'b00});
    m_clr = 18'h3C3C3;
    wr(3'b011, {m_clr, 2'b00});
    wr(3'b100, 20'h00003);
    m_code = m_clr;
    m_out  = m_clr;
    check("R9 clear and load", 32'(dac_code), 32'(m_out));
  endtask

  task automatic t_bad_length();
    logic [23:0] g;
    frame({1'b0, 3'b010, 20'h11111}, 23, g);
    check("R5 short frame", 32'(ctrl_bits), 32'(m_ctrl));
    frame({1'b0, 3'b010, 20'h22222}, 25, g);
    check("R5 long frame", 32'(ctrl_bits), 32'(m_ctrl));
    frame({1'b0, 3'b001, 20'h33333}, 23, g);
    wr(3'b100, 20'h00001);
    check("R5 short code frame", 32'(dac_code), 32'(m_out));
  endtask

  task automatic t_soft_read();
    logic [23:0] g;
    rd(3'b100, g);
    check("R7 soft read image", 32'(g), 32'h00C00000);
    check_outputs("R7 read frame no change");
  endtask

  task automatic t_bad_addr();
    logic [23:0] g;
    for (int a = 5; a < 8; a++) wr(3'(a), 20'hFFFFF);
    check_outputs("R12 reserved addresses");
    rd(3'b001, g);
    check("R12 code reg untouched", 32'(g), 32'({1'b1, 3'b001, m_code, 2'b00}));
  endtask

  task automatic t_soft_reset();
    logic [23:0] g;
    wr(3'b100, 20'h00007);
    m_code = '0; m_out = '0; m_clr = '0; m_ctrl = '0;
    check_outputs("R10 soft reset");
    rd(3'b011, g);
    check("R10 clear code reset", 32'(g), 32'h00B00000);
    rd(3'b001, g);
    check("R10 code reg reset", 32'(g), 32'h00900000);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1;
    t_reset();
    rst = 1'b0;
    #100;
    t_reset();
    t_nop_and_idle();
    t_code_write();
    t_load();
    t_ctrl();
    t_clear();
    t_bad_length();
    t_soft_read();
    t_bad_addr();
    t_soft_reset();
    finish_run();
  end

  initial begin
    #1_500_000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule